// File: doc/BRIEF.md
# DMA Channel Common Control Register Bank

This block is the shared control and status register file of an N-channel DMA controller. A CPU reaches it through a simple 32-bit register bus with one write strobe and an always-valid read path. Each channel is one bit in every vector register. The bank holds the channel enables, the interrupt enables and three latched event flags: error, completion A and completion B. It also holds a global controller enable and the address of the descriptor table.

The per-channel engines report their state to the bank. They send level-valued busy and active status, plus single-cycle event pulses. In return the bank drives the channel enables, the global enable and the table base. It also issues one-cycle action strobes, which request an abort, mark a descriptor valid, or fire a software trigger. A single interrupt line goes to the CPU.

The enable vectors never take a plain write. Software sets bits through one address and clears them through another, so it can change one channel without a read-modify-write. The event flags clear when a one is written to them. An abort request reaches only channels that are already disabled and idle.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every stored register, every strobe output, `ctl_enable`, `tbl_base` and `irq` are zero.
- R2: The control word at offset 0x00 holds bit 0 as the global enable, driven on `ctl_enable`; its other bits read zero.
- R3: The table base at offset 0x04 stores the written address with its low `TBL_ALIGN` bits (default 9) forced to zero, and drives it on `tbl_base`.
- R4: A write to the enable-set address 0x0C sets the channel enables (read at 0x08) for each one bit; zero bits and bits at or above `NCH` have no effect.
- R5: A write to the enable-clear address 0x10 clears the channel enables for each one bit; zero bits have no effect.
- R6: The interrupt enables (read at 0x14) are set through 0x18 and cleared through 0x1C with the same one-bit rules as R4 and R5.
- R7: A pulse on a channel's error, A or B event input latches that channel's flag. The flags read at 0x28, 0x2C and 0x30. Writing a one to a flag bit clears it.
- R8: If an event pulse and a clearing write hit the same flag bit in the same cycle, the flag ends set.
- R9: A write to 0x38 (set-valid) or 0x3C (trigger) raises the matching strobe bits for exactly the one cycle after the write edge; zero bits raise nothing.
- R10: A write to 0x34 (abort) raises `abort_strobe` for the one cycle after the write edge, only on selected channels that were both disabled and not busy at the write.
- R11: Offsets 0x20 and 0x24 read the live `eng_active` and `eng_busy` inputs.
- R12: `irq` is high exactly when some channel has a latched error, A or B flag whose interrupt enable is set.
- R13: Reads of 0x0C, 0x10, 0x18, 0x1C, 0x34, 0x38, 0x3C and any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_active | input | NCH | Per-channel active status |
| eng_busy | input | NCH | Per-channel busy status |
| eng_err | input | NCH | Per-channel error event pulse |
| eng_done_a | input | NCH | Per-channel completion-A event pulse |
| eng_done_b | input | NCH | Per-channel completion-B event pulse |
| ctl_enable | output | 1 | Global controller enable |
| tbl_base | output | 32 | Aligned descriptor table address |
| ch_enable | output | NCH | Channel enables |
| abort_strobe | output | NCH | One-cycle abort request |
| valid_strobe | output | NCH | One-cycle descriptor-valid request |
| trig_strobe | output | NCH | One-cycle software trigger |
| irq | output | 1 | Combined CPU interrupt |

## Verification
The assertions assume that the engines' busy input is stable around an abort write. They also assume that the bus presents one write at a time at a decoded offset. They make no assumption about how often the event pulses arrive, so one check is that a pulse landing on a clearing write always leaves its flag set. The stimulus moves inputs only at falling edges. It holds each event pulse for exactly one cycle and issues every abort only after the channel's enable has been cleared, or deliberately with some selected channels still enabled or busy, so that the gating can be observed.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH       = 16,
  parameter int TBL_ALIGN = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] eng_active,
  input  logic [NCH-1:0] eng_busy,
  input  logic [NCH-1:0] eng_err,
  input  logic [NCH-1:0] eng_done_a,
  input  logic [NCH-1:0] eng_done_b,
  output logic           ctl_enable,
  output logic [31:0]    tbl_base,
  output logic [NCH-1:0] ch_enable,
  output logic [NCH-1:0] abort_strobe,
  output logic [NCH-1:0] valid_strobe,
  output logic [NCH-1:0] trig_strobe,
  output logic           irq
);
  localparam logic [7:0] A_CTRL  = 8'h00, A_BASE  = 8'h04, A_EN    = 8'h08,
                         A_ENSET = 8'h0C, A_ENCLR = 8'h10, A_IE    = 8'h14,
                         A_IESET = 8'h18, A_IECLR = 8'h1C, A_ACT   = 8'h20,
                         A_BUSY  = 8'h24, A_ERR   = 8'h28, A_FA    = 8'h2C,
                         A_FB    = 8'h30, A_ABORT = 8'h34, A_VALID = 8'h38,
                         A_TRIG  = 8'h3C;
  localparam logic [31:0] BASE_MASK = ~((32'd1 << TBL_ALIGN) - 32'd1);

  logic [NCH-1:0] wd, irq_en, err_f, fa_f, fb_f;

  assign wd = bus_wdata[NCH-1:0];

  function automatic logic [NCH-1:0] hit(input logic [7:0] a);
    return (bus_wr && bus_addr == a) ? bus_wdata[NCH-1:0] : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_enable   <= 1'b0;
      tbl_base     <= '0;
      ch_enable    <= '0;
      irq_en       <= '0;
      err_f        <= '0;
      fa_f         <= '0;
      fb_f         <= '0;
      abort_strobe <= '0;
      valid_strobe <= '0;
      trig_strobe  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctl_enable <= bus_wdata[0];
      if (bus_wr && bus_addr == A_BASE) tbl_base   <= bus_wdata & BASE_MASK;
      ch_enable    <= (ch_enable | hit(A_ENSET)) & ~hit(A_ENCLR);
      irq_en       <= (irq_en | hit(A_IESET)) & ~hit(A_IECLR);
      err_f        <= (err_f & ~hit(A_ERR)) | eng_err;
      fa_f         <= (fa_f  & ~hit(A_FA))  | eng_done_a;
      fb_f         <= (fb_f  & ~hit(A_FB))  | eng_done_b;
      abort_strobe <= hit(A_ABORT) & ~ch_enable & ~eng_busy;
      valid_strobe <= hit(A_VALID);
      trig_strobe  <= hit(A_TRIG);
    end
  end

  assign irq = |((err_f | fa_f | fb_f) & irq_en);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {31'd0, ctl_enable};
      A_BASE:  bus_rdata = tbl_base;
      A_EN:    bus_rdata = 32'(ch_enable);
      A_IE:    bus_rdata = 32'(irq_en);
      A_ACT:   bus_rdata = 32'(eng_active);
      A_BUSY:  bus_rdata = 32'(eng_busy);
      A_ERR:   bus_rdata = 32'(err_f);
      A_FA:    bus_rdata = 32'(fa_f);
      A_FB:    bus_rdata = 32'(fb_f);
      default: bus_rdata = 32'd0;
    endcase
  end

  assert_en_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable != $past(ch_enable)) |->
      $past(bus_wr && (bus_addr == A_ENSET || bus_addr == A_ENCLR)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_f & $past(eng_err)) == $past(eng_err)) &&
    ((fa_f & $past(eng_done_a)) == $past(eng_done_a)) &&
    ((fb_f & $past(eng_done_b)) == $past(eng_done_b)));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~err_f & $past(err_f)) != '0) |-> $past(bus_wr && bus_addr == A_ERR));

  assert_strobe_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_strobe != '0) |-> $past(bus_wr && bus_addr == A_TRIG &&
                                  ((bus_wdata[NCH-1:0] & trig_strobe) == trig_strobe)));

  assert_abort_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_strobe & ($past(ch_enable) | $past(eng_busy))) == '0);

  assert_irq_needs_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en != '0));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  localparam int NCH = 16;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, tbl_base;
  logic [NCH-1:0] eng_active = '0, eng_busy = '0, eng_err = '0, eng_done_a = '0, eng_done_b = '0;
  logic ctl_enable, irq;
  logic [NCH-1:0] ch_enable, abort_strobe, valid_strobe, trig_strobe;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dma_chan_regs #(.NCH(NCH), .TBL_ALIGN(9)) i_dma_chan_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .eng_active, .eng_busy, .eng_err, .eng_done_a, .eng_done_b,
    .ctl_enable, .tbl_base, .ch_enable, .abort_strobe, .valid_strobe,
    .trig_strobe, .irq);

  // kind(1: 1=read check, 0=write) | addr(8) | data or expected(32)
  localparam int NV = 22;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0},           // R1
    {1'b0, 8'h00, 32'hFFFF_FFFF},
    {1'b1, 8'h00, 32'h1},           // R2
    {1'b0, 8'h04, 32'h1234_5FFF},
    {1'b1, 8'h04, 32'h1234_5E00},   // R3
    {1'b0, 8'h0C, 32'h0000_00A5},
    {1'b1, 8'h08, 32'h0000_00A5},   // R4
    {1'b0, 8'h0C, 32'h0000_000F},
    {1'b1, 8'h08, 32'h0000_00AF},   // R4 zero bits keep
    {1'b0, 8'h10, 32'h0000_0021},
    {1'b1, 8'h08, 32'h0000_008E},   // R5
    {1'b0, 8'h0C, 32'h0001_0000},
    {1'b1, 8'h08, 32'h0000_008E},   // R4 bit above NCH
    {1'b0, 8'h18, 32'h0000_0003},
    {1'b1, 8'h14, 32'h0000_0003},   // R6
    {1'b0, 8'h1C, 32'h0000_0001},
    {1'b1, 8'h14, 32'h0000_0002},   // R6
    {1'b1, 8'h0C, 32'h0},           // R13
    {1'b1, 8'h10, 32'h0},           // R13
    {1'b1, 8'h34, 32'h0},           // R13
    {1'b1, 8'h3C, 32'h0},           // R13
    {1'b1, 8'h7C, 32'h0}            // R13
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1; chk(req, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes", {abort_strobe, valid_strobe}, 32'h0);
    chk("R1 outs", {tbl_base[30:0], ctl_enable}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) rd("R2-table", VEC[i][39:32], VEC[i][31:0]);
      else wr(VEC[i][39:32], VEC[i][31:0]);
    end
    chk("R2 ctl_enable", {31'd0, ctl_enable}, 32'h1);
    chk("R3 tbl_base", tbl_base, 32'h1234_5E00);
    chk("R4 ch_enable", 32'(ch_enable), 32'h8E);

    // R7 error flag latches; channel 2 not interrupt enabled
    @(negedge clk); eng_err = 16'h0004;
    @(negedge clk); eng_err = '0;
    rd("R7 err", 8'h28, 32'h4);
    chk("R12 irq masked", {31'd0, irq}, 32'h0);
    @(negedge clk); eng_done_a = 16'h0002;
    @(negedge clk); eng_done_a = '0;
    rd("R7 flagA", 8'h2C, 32'h2);
    chk("R12 irq on", {31'd0, irq}, 32'h1);
    wr(8'h2C, 32'h2);
    rd("R7 flagA clear", 8'h2C, 32'h0);
    chk("R12 irq off", {31'd0, irq}, 32'h0);
    wr(8'h28, 32'h0);
    rd("R7 zero write keeps", 8'h28, 32'h4);

    // R8 same-cycle set and clear
    @(negedge clk); eng_done_b = 16'h0008; bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h8;
    @(negedge clk); eng_done_b = '0; bus_wr = 1'b0;
    rd("R8 set wins", 8'h30, 32'h8);
    wr(8'h30, 32'h8);
    rd("R7 flagB clear", 8'h30, 32'h0);

    // R11 status read-back
    eng_busy = 16'h0030; eng_active = 16'h000C;
    rd("R11 active", 8'h20, 32'h0C);
    rd("R11 busy", 8'h24, 32'h30);

    // R10 abort gating: enabled 0x8E, busy 0x30
    wr(8'h34, 32'h0000_00FF);
    chk("R10 abort", 32'(abort_strobe), 32'h41);
    @(negedge clk);
    chk("R10 abort one cycle", 32'(abort_strobe), 32'h0);

    // R9 set-valid and trigger strobes
    wr(8'h38, 32'h0000_8001);
    chk("R9 valid", 32'(valid_strobe), 32'h8001);
    chk("R9 trig idle", 32'(trig_strobe), 32'h0);
    @(negedge clk);
    chk("R9 valid one cycle", 32'(valid_strobe), 32'h0);
    wr(8'h3C, 32'h0000_003C);
    chk("R9 trig", 32'(trig_strobe), 32'h3C);
    @(negedge clk);
    chk("R9 trig one cycle", 32'(trig_strobe), 32'h0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset ch_enable", 32'(ch_enable), 32'h0);
    rd("R1 reset err", 8'h28, 32'h0);
    chk("R1 reset ctl", {31'd0, ctl_enable}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule